// File: doc/BRIEF.md
# Warp Branch Divergence Controller

This block tracks the program counter and the active-thread mask of one warp of lock-step threads as it passes through conditional branches. When a branch resolves, the caller presents one taken bit per thread. Threads that are already disabled do not count. If every enabled thread goes the same way, only the PC moves. If the enabled threads split, the controller records the pending work on a small reconvergence stack and runs the taken group first. At the reconvergence point it switches to the waiting group. At the second arrival it restores the pre-branch mask and PC.

Sequential progress comes in on an arrival port, which carries the PC the warp has reached. An arrival at the PC that closes the current path pops the stack. Any other arrival just updates the PC. The caller raises the branch strobe only once every thread's outcome is known. One instance serves one warp, so warps never affect each other. Nesting is bounded by the stack depth. A divergent branch that would not fit raises a sticky error instead.

Top module: `simt_diverge_ctrl`

## Requirements
- R1: Reset sets the PC to RESET_PC (default 0), the mask to all ones and the overflow error to 0.
- R2: A branch where all enabled threads have their taken bit set moves the PC to the target on the next clock and keeps the mask. Taken bits of disabled threads are ignored.
- R3: A branch where no enabled thread has its taken bit set moves the PC to the fall-through on the next clock and keeps the mask.
- R4: A divergent branch (enabled threads disagree) sets the PC to the target and the mask to (old mask AND taken) on the next clock.
- R5: After a divergence, the first arrival at that branch's reconvergence PC switches to the fall-through PC, with mask (pre-branch mask AND NOT taken).
- R6: The second arrival at that reconvergence PC sets the PC to it and restores the pre-branch mask.
- R7: An arrival at any other PC, or with no open divergence, sets the PC to the arrival PC and leaves the mask unchanged.
- R8: Divergences nest up to DEPTH/2 levels (4 by default), and the innermost one is resolved first.
- R9: A divergent branch with fewer than two free stack entries sets the overflow error. PC and mask stay unchanged, and the error stays set until reset.
- R10: With the branch strobe low, the taken vector and branch PCs are ignored. A branch presented in the same cycle as an arrival takes priority, and the arrival is dropped.
- R11: The active mask is never all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Branch resolved for all threads |
| br_taken | input | THREADS | Per-thread taken outcome |
| br_target | input | PC_W | Taken-path PC |
| br_fall | input | PC_W | Fall-through PC |
| br_reconv | input | PC_W | Reconvergence PC of this branch |
| arr_valid | input | 1 | Warp reached a new PC |
| arr_pc | input | PC_W | PC reached |
| pc_o | output | PC_W | Current warp PC |
| mask_o | output | THREADS | Current active-thread mask |
| ovf_err | output | 1 | Sticky stack overflow error |

## Verification
Every decision is registered, so a wrong stack entry or a wrong path-end PC shows up at pc_o and mask_o one clock after the arrival that pops it. A swapped mask half gives the wrong thread set right after the first reconvergence. A lost pre-branch mask is visible at the second reconvergence. A miscounted depth makes the overflow flag appear one nesting level early or late. The table-driven nested run exposes each of these at the cycle where the faulty pop or push takes effect.

// File: rtl/simt_pkg.sv
package simt_pkg;
  typedef enum logic [1:0] {EV_NONE, EV_UNIFORM, EV_DIVERGE, EV_OVERFLOW} br_ev_e;

  // true when a stack holding `used` of `cap` entries can take `need` more
  function automatic logic room_for(input int used, input int cap, input int need);
    return (used + need) <= cap;
  endfunction
endpackage

// File: rtl/simt_br_eval.sv
module simt_br_eval #(
  parameter int THREADS = 32
) (
  input  logic               br_valid,
  input  logic [THREADS-1:0] act_mask,
  input  logic [THREADS-1:0] taken,
  input  logic               room2,
  output simt_pkg::br_ev_e   ev,
  output logic               go_taken,
  output logic [THREADS-1:0] t_mask,
  output logic [THREADS-1:0] n_mask
);
  always_comb begin
    t_mask   = act_mask & taken;
    n_mask   = act_mask & ~taken;
    go_taken = (t_mask == act_mask);
    if (!br_valid)
      ev = simt_pkg::EV_NONE;
    else if (t_mask == '0 || n_mask == '0)
      ev = simt_pkg::EV_UNIFORM;
    else if (room2)
      ev = simt_pkg::EV_DIVERGE;
    else
      ev = simt_pkg::EV_OVERFLOW;
  end
endmodule

// File: rtl/simt_rstack.sv
module simt_rstack #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push2,
  input  logic [W-1:0] push_lo,
  input  logic [W-1:0] push_hi,
  input  logic         pop,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         room2_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int DW = $clog2(DEPTH + 1);

  logic [DW-1:0] cnt;
  logic [W-1:0]  ent [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push2 && cnt == DW'(i))
        ent[i] <= push_lo;
      else if (push2 && (cnt + DW'(1)) == DW'(i))
        ent[i] <= push_hi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (push2)
      cnt <= cnt + DW'(2);
    else if (pop)
      cnt <= cnt - DW'(1);
  end

  assign top_o   = ent[AW'(cnt - DW'(1))];
  assign empty_o = (cnt == '0);
  assign room2_o = simt_pkg::room_for(int'(cnt), DEPTH, 2);
endmodule

// File: rtl/simt_diverge_ctrl.sv
module simt_diverge_ctrl #(
  parameter int               THREADS  = 32,
  parameter int               PC_W     = 32,
  parameter int               DEPTH    = 8,
  parameter logic [PC_W-1:0]  RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               br_valid,
  input  logic [THREADS-1:0] br_taken,
  input  logic [PC_W-1:0]    br_target,
  input  logic [PC_W-1:0]    br_fall,
  input  logic [PC_W-1:0]    br_reconv,
  input  logic               arr_valid,
  input  logic [PC_W-1:0]    arr_pc,
  output logic [PC_W-1:0]    pc_o,
  output logic [THREADS-1:0] mask_o,
  output logic               ovf_err
);
  // entry layout: {end_valid, end_pc, resume_pc, mask}
  localparam int EW = 1 + 2 * PC_W + THREADS;

  simt_pkg::br_ev_e   ev;
  logic               go_taken, room2, stk_empty;
  logic [THREADS-1:0] t_mask, n_mask;
  logic [EW-1:0]      ent_lo, ent_hi, ent_top;
  logic [PC_W-1:0]    end_pc;
  logic               end_vld;

  // named events for the checker
  logic ev_uniform, ev_diverge, ev_ovf, ev_pop;

  simt_br_eval #(.THREADS(THREADS)) u_eval (
    .br_valid (br_valid),
    .act_mask (mask_o),
    .taken    (br_taken),
    .room2    (room2),
    .ev       (ev),
    .go_taken (go_taken),
    .t_mask   (t_mask),
    .n_mask   (n_mask)
  );

  assign ev_uniform = (ev == simt_pkg::EV_UNIFORM);
  assign ev_diverge = (ev == simt_pkg::EV_DIVERGE);
  assign ev_ovf     = (ev == simt_pkg::EV_OVERFLOW);
  assign ev_pop     = arr_valid && !br_valid && end_vld && !stk_empty && (arr_pc == end_pc);

  assign ent_lo = {end_vld, end_pc, br_reconv, mask_o};
  assign ent_hi = {1'b1, br_reconv, br_fall, n_mask};

  simt_rstack #(.W(EW), .DEPTH(DEPTH)) u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .push2   (ev_diverge),
    .push_lo (ent_lo),
    .push_hi (ent_hi),
    .pop     (ev_pop),
    .top_o   (ent_top),
    .empty_o (stk_empty),
    .room2_o (room2)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_o    <= RESET_PC;
      mask_o  <= '1;
      end_pc  <= '0;
      end_vld <= 1'b0;
      ovf_err <= 1'b0;
    end else begin
      unique case (ev)
        simt_pkg::EV_UNIFORM:  pc_o <= go_taken ? br_target : br_fall;
        simt_pkg::EV_DIVERGE: begin
          pc_o    <= br_target;
          mask_o  <= t_mask;
          end_pc  <= br_reconv;
          end_vld <= 1'b1;
        end
        simt_pkg::EV_OVERFLOW: ovf_err <= 1'b1;
        default: begin
          if (ev_pop)
            {end_vld, end_pc, pc_o, mask_o} <= ent_top;
          else if (arr_valid)
            pc_o <= arr_pc;
        end
      endcase
    end
  end
endmodule

// File: rtl/simt_diverge_chk.sv
module simt_diverge_chk #(
  parameter int THREADS = 32,
  parameter int PC_W    = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               br_valid,
  input logic [THREADS-1:0] br_taken,
  input logic [PC_W-1:0]    br_target,
  input logic               arr_valid,
  input logic [PC_W-1:0]    pc_o,
  input logic [THREADS-1:0] mask_o,
  input logic               ovf_err,
  input logic               ev_uniform,
  input logic               ev_diverge,
  input logic               ev_ovf,
  input logic               ev_pop
);
  AST_UNIFORM_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ev_uniform |=> $stable(mask_o)); // R2
  AST_DIVERGE_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_diverge |=> (mask_o == ($past(mask_o) & $past(br_taken))) && (pc_o == $past(br_target))); // R4
  AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mask_o != '0); // R11
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err); // R9
  AST_OVF_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |=> $stable(pc_o) && $stable(mask_o) && ovf_err); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_valid && !arr_valid) |=> $stable(pc_o) && $stable(mask_o)); // R10
  AST_BR_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |-> !ev_pop); // R10
endmodule

bind simt_diverge_ctrl simt_diverge_chk #(.THREADS(THREADS), .PC_W(PC_W)) u_chk (.*);

// File: tb/sim_simt_diverge_ctrl.sv
module sim_simt_diverge_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        br_valid, arr_valid;
  logic [31:0] br_taken, br_target, br_fall, br_reconv, arr_pc;
  logic [31:0] pc_o, mask_o;
  logic        ovf_err;
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  simt_diverge_ctrl u0 (.*);

  // kind: 0 idle (junk on branch pins), 1 branch, 2 arrival
  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] taken, tgt, fall, rc, arr, epc, emask;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 32'h0, 32'h0, 32'h0, 32'h0, 32'h10, 32'h10, 32'hFFFFFFFF, 4'd7},              // R7
    '{2'd1, 32'hFFFFFFFF, 32'h100, 32'h14, 32'h200, 32'h0, 32'h100, 32'hFFFFFFFF, 4'd2},  // R2
    '{2'd1, 32'h0, 32'h300, 32'h104, 32'h400, 32'h0, 32'h104, 32'hFFFFFFFF, 4'd3},        // R3
    '{2'd1, 32'h0000FFFF, 32'h500, 32'h108, 32'h600, 32'h0, 32'h500, 32'h0000FFFF, 4'd4}, // R4
    '{2'd1, 32'hFFFF0000, 32'h700, 32'h504, 32'h800, 32'h0, 32'h504, 32'h0000FFFF, 4'd2}, // R2 inactive bits
    '{2'd2, 32'h0, 32'h0, 32'h0, 32'h0, 32'h520, 32'h520, 32'h0000FFFF, 4'd7},            // R7
    '{2'd1, 32'h000000FF, 32'h900, 32'h524, 32'h580, 32'h0, 32'h900, 32'h000000FF, 4'd8}, // R8 nested
    '{2'd2, 32'h0, 32'h0, 32'h0, 32'h0, 32'h580, 32'h524, 32'h0000FF00, 4'd5},            // R5 inner
    '{2'd2, 32'h0, 32'h0, 32'h0, 32'h0, 32'h580, 32'h580, 32'h0000FFFF, 4'd6},            // R6 inner
    '{2'd2, 32'h0, 32'h0, 32'h0, 32'h0, 32'h600, 32'h108, 32'hFFFF0000, 4'd5},            // R5 outer
    '{2'd0, 32'h0F0F0F0F, 32'hDEAD, 32'hBEEF, 32'h600, 32'h0, 32'h108, 32'hFFFF0000, 4'd10}, // R10
    '{2'd2, 32'h0, 32'h0, 32'h0, 32'h0, 32'h600, 32'h600, 32'hFFFFFFFF, 4'd6},            // R6 outer
    '{2'd2, 32'h0, 32'h0, 32'h0, 32'h0, 32'h600, 32'h600, 32'hFFFFFFFF, 4'd7}             // R7 empty stack
  };

  task automatic check(input string tag, input logic [31:0] epc, input logic [31:0] emask,
                       input logic eovf);
    checks++;
    if (pc_o !== epc || mask_o !== emask || ovf_err !== eovf) begin
      fails++;
      $display("FAIL %s pc=%h mask=%h ovf=%b expected pc=%h mask=%h ovf=%b",
               tag, pc_o, mask_o, ovf_err, epc, emask, eovf);
    end
  endtask

  // drive at a falling edge, result is registered at the next rising edge
  task automatic apply(input logic bv, input logic [31:0] tk, input logic [31:0] tg,
                       input logic [31:0] fl, input logic [31:0] rc,
                       input logic av, input logic [31:0] ap);
    br_valid = bv; br_taken = tk; br_target = tg; br_fall = fl; br_reconv = rc;
    arr_valid = av; arr_pc = ap;
    @(negedge clk);
    br_valid = 1'b0; arr_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; br_valid = 1'b0; arr_valid = 1'b0;
    br_taken = '0; br_target = '0; br_fall = '0; br_reconv = '0; arr_pc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", 32'h0, 32'hFFFFFFFF, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].kind == 2'd1 || VECS[i].kind == 2'd0 ? VECS[i].kind == 2'd1 : 1'b0,
            VECS[i].taken, VECS[i].tgt, VECS[i].fall, VECS[i].rc,
            VECS[i].kind == 2'd2, VECS[i].arr);
      check($sformatf("R%0d row%0d", VECS[i].req, i), VECS[i].epc, VECS[i].emask, 1'b0);
    end

    // R8: four nested divergences fill the stack
    apply(1, 32'h0000FFFF, 32'h1100, 32'h1104, 32'h1180, 0, 0);
    check("R8 lvl1", 32'h1100, 32'h0000FFFF, 1'b0);
    apply(1, 32'h000000FF, 32'h1200, 32'h1204, 32'h1280, 0, 0);
    check("R8 lvl2", 32'h1200, 32'h000000FF, 1'b0);
    apply(1, 32'h0000000F, 32'h1300, 32'h1304, 32'h1380, 0, 0);
    check("R8 lvl3", 32'h1300, 32'h0000000F, 1'b0);
    apply(1, 32'h00000003, 32'h1400, 32'h1404, 32'h1480, 0, 0);
    check("R8 lvl4", 32'h1400, 32'h00000003, 1'b0);
    // R9: a fifth divergence overflows, state frozen
    apply(1, 32'h00000001, 32'h1500, 32'h1504, 32'h1580, 0, 0);
    check("R9 overflow", 32'h1400, 32'h00000003, 1'b1);
    // R10: branch and arrival together, branch wins and no pop happens
    apply(1, 32'h00000003, 32'h2000, 32'h2004, 32'h2080, 1, 32'h1480);
    check("R10 priority", 32'h2000, 32'h00000003, 1'b1);
    // R5 with R9 sticky: arrival at innermost end pops the waiting group
    apply(0, 0, 0, 0, 0, 1, 32'h1480);
    check("R5 after ovf", 32'h1404, 32'h0000000C, 1'b1);
    // R1: reset clears the error
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 rereset", 32'h0, 32'hFFFFFFFF, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule